// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block turns a 16-bit segment value and a 16-bit offset into a physical byte address. The segment value is shifted left by four bits, which places every segment on a 16-byte boundary. The offset is then added, so each segment covers a 64 KB window. The sum is 21 bits wide. Its top bit is set when the window crosses 1 MB, which happens only for segments near FFFFh.

The unit holds four segment registers: code, data, extra and stack. A write port loads them. Each request carries a tag that names the role of the offset: instruction pointer, stack pointer, base pointer, base register, source index, string destination index, or a direct number. The tag picks the default segment. A valid override input replaces that choice.

A high-memory enable decides what happens to bit 20 of the sum. When the enable is high, bit 20 is kept, so addresses from 0FFFF0h up to 10FFEFh can be reached. When it is low, bit 20 is forced to zero and the address wraps inside 1 MB. A separate flag reports bit 20 of the unmasked sum in both cases. Results are registered and appear one clock after the request.

Top module: `seg_addr_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, out_valid, phys_addr, above_1m and seg_used are all zero. All four segment registers read back as zero.
- R2: For a request accepted on a clock edge, out_valid is high for exactly the following cycle. In that cycle phys_addr equals (segment << 4) + offset. For example, segment 1000h with offset 2000h gives 12000h.
- R3: Segment codes are code=0, data=1, extra=2 and stack=3. Role tag 0 (instruction pointer) selects the code segment, and seg_used shows 0.
- R4: Role tags 1 (stack pointer) and 2 (base pointer) select the stack segment, and seg_used shows 3.
- R5: Role tags 3 (base register), 4 (source index) and 6 (direct number), and the unused tag 7, select the data segment, and seg_used shows 1.
- R6: Role tag 5 (string destination index) selects the extra segment, and seg_used shows 2.
- R7: When ovr_valid is high with a request, the segment coded on ovr_sel is used whatever the role tag.
- R8: With hma_en high, bit 20 of the sum is kept. For example, FFFFh:FFFFh gives 10FFEFh and FFFFh:0000h gives 0FFFF0h.
- R9: With hma_en low, bit 20 of phys_addr is zero, so FFFFh:0010h gives 00000h.
- R10: above_1m equals bit 20 of the unmasked sum, whatever the value of hma_en.
- R11: A write stores seg_wr_data in the register coded by seg_wr_sel. Requests in later cycles use the new value. A request in the same cycle as the write uses the old value.
- R12: In a cycle after an edge with no request, out_valid is zero, and phys_addr, above_1m and seg_used keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_wr_en | input | 1 | Load strobe for a segment register |
| seg_wr_sel | input | 2 | Segment register to load (code 0, data 1, extra 2, stack 3) |
| seg_wr_data | input | 16 | Value to load |
| req_valid | input | 1 | Address request strobe |
| req_role | input | 3 | Role tag of the offset |
| req_offset | input | 16 | Offset value |
| ovr_valid | input | 1 | Segment override present |
| ovr_sel | input | 2 | Segment used when the override is present |
| hma_en | input | 1 | Keep bit 20 of the sum when high |
| out_valid | output | 1 | Result present |
| phys_addr | output | 21 | Physical address |
| above_1m | output | 1 | Unmasked sum is at or above 1 MB |
| seg_used | output | 2 | Segment code that formed the address |

## Verification
Every result (phys_addr, above_1m, seg_used and out_valid) is due exactly one clock edge after the request. The bench drives inputs on the falling edge and samples on the next falling edge, which is half a cycle after the one register stage. A segment write is applied on the same edge. The bench therefore expects a request driven together with a write to see the old value, and a request driven on any later falling edge to see the new one. After each request the bench leaves one idle cycle and checks that the outputs are held.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    localparam int SEG_W    = 16;
    localparam int OFF_W    = 16;
    localparam int SHIFT_W  = 4;
    localparam int NUM_SEG  = 4;
    localparam int SEL_W    = $clog2(NUM_SEG);
    localparam int ROLE_W   = 3;
    localparam int BASE_W   = SEG_W + SHIFT_W;
    localparam int ADDR_W   = ((BASE_W > OFF_W) ? BASE_W : OFF_W) + 1;

    typedef enum logic [SEL_W-1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_EXTRA = 2'd2,
        SEG_STACK = 2'd3
    } seg_id_e;

    typedef enum logic [ROLE_W-1:0] {
        ROLE_IP     = 3'd0,
        ROLE_SP     = 3'd1,
        ROLE_BP     = 3'd2,
        ROLE_BASE   = 3'd3,
        ROLE_SRC    = 3'd4,
        ROLE_DSTSTR = 3'd5,
        ROLE_DIRECT = 3'd6,
        ROLE_SPARE  = 3'd7
    } role_e;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic              above;
        logic [SEL_W-1:0]  seg;
    } out_state_t;

endpackage

// File: rtl/seg_bank.sv
module seg_bank
    import seg_addr_pkg::*;
#(
    parameter int N = NUM_SEG,
    parameter int W = SEG_W,
    localparam int SW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_sel,
    input  logic [W-1:0]  wr_data,
    input  logic [SW-1:0] rd_sel,
    output logic [W-1:0]  rd_data
);

    logic [W-1:0] bank_q [N];

    for (genvar g = 0; g < N; g++) begin : g_reg
        logic [W-1:0] val_d;
        always_comb begin
            val_d = bank_q[g];
            if (wr_en && (wr_sel == SW'(g))) begin
                val_d = wr_data;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else begin
                bank_q[g] <= val_d;
            end
        end

        AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) && $past(wr_en) && ($past(wr_sel) == SW'(g))
            |-> bank_q[g] == $past(wr_data)); // R11
    end

    assign rd_data = bank_q[rd_sel];

endmodule

// File: rtl/seg_pick.sv
module seg_pick
    import seg_addr_pkg::*;
(
    input  logic [ROLE_W-1:0] role,
    input  logic              ovr_valid,
    input  logic [SEL_W-1:0]  ovr_sel,
    output logic [SEL_W-1:0]  sel
);

    logic [SEL_W-1:0] dflt;

    always_comb begin
        unique case (role_e'(role))
            ROLE_IP:             dflt = SEG_CODE;
            ROLE_SP, ROLE_BP:    dflt = SEG_STACK;
            ROLE_DSTSTR:         dflt = SEG_EXTRA;
            default:             dflt = SEG_DATA;
        endcase
        sel = ovr_valid ? ovr_sel : dflt;
    end

endmodule

// File: rtl/seg_sum.sv
module seg_sum
    import seg_addr_pkg::*;
(
    input  logic [SEG_W-1:0]  seg,
    input  logic [OFF_W-1:0]  off,
    input  logic              keep_top,
    output logic [ADDR_W-1:0] addr,
    output logic              top_raw
);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] raw;

    always_comb begin
        base    = ADDR_W'({seg, {SHIFT_W{1'b0}}});
        raw     = base + ADDR_W'(off);
        top_raw = raw[ADDR_W-1];
        addr    = {raw[ADDR_W-1] & keep_top, raw[ADDR_W-2:0]};
    end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import seg_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seg_wr_en,
    input  logic [1:0]        seg_wr_sel,
    input  logic [15:0]       seg_wr_data,
    input  logic              req_valid,
    input  logic [2:0]        req_role,
    input  logic [15:0]       req_offset,
    input  logic              ovr_valid,
    input  logic [1:0]        ovr_sel,
    input  logic              hma_en,
    output logic              out_valid,
    output logic [20:0]       phys_addr,
    output logic              above_1m,
    output logic [1:0]        seg_used
);

    logic [SEL_W-1:0]  pick_sel;
    logic [SEG_W-1:0]  seg_val;
    logic [ADDR_W-1:0] sum_addr;
    logic              sum_top;
    out_state_t        st_d, st_q;

    seg_pick u_pick (
        .role      (req_role),
        .ovr_valid (ovr_valid),
        .ovr_sel   (ovr_sel),
        .sel       (pick_sel)
    );

    seg_bank #(.N(NUM_SEG), .W(SEG_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (seg_wr_en),
        .wr_sel  (seg_wr_sel),
        .wr_data (seg_wr_data),
        .rd_sel  (pick_sel),
        .rd_data (seg_val)
    );

    seg_sum u_sum (
        .seg      (seg_val),
        .off      (req_offset),
        .keep_top (hma_en),
        .addr     (sum_addr),
        .top_raw  (sum_top)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = req_valid;
        if (req_valid) begin
            st_d.addr  = sum_addr;
            st_d.above = sum_top;
            st_d.seg   = pick_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign phys_addr = st_q.addr;
    assign above_1m  = st_q.above;
    assign seg_used  = st_q.seg;

    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(req_valid)); // R2
    AST_REQ_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(req_valid) |-> out_valid); // R2
    AST_TOP_BIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && phys_addr[ADDR_W-1] |-> $past(hma_en) && above_1m); // R9
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(req_valid) |-> $stable(phys_addr) && $stable(above_1m)); // R12
    AST_OVR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && ovr_valid |=> seg_used == $past(ovr_sel)); // R7
    AST_IP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !ovr_valid && (req_role == 3'd0) |=> seg_used == 2'd0); // R3
    AST_STR_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !ovr_valid && (req_role == 3'd5) |=> seg_used == 2'd2); // R6

endmodule

// File: tb/seg_addr_gen_tb.sv
`timescale 1ns/1ps
module seg_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        seg_wr_en = 1'b0;
    logic [1:0]  seg_wr_sel = '0;
    logic [15:0] seg_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_role = '0;
    logic [15:0] req_offset = '0;
    logic        ovr_valid = 1'b0;
    logic [1:0]  ovr_sel = '0;
    logic        hma_en = 1'b0;
    logic        out_valid;
    logic [20:0] phys_addr;
    logic        above_1m;
    logic [1:0]  seg_used;

    int total = 0;
    int bad = 0;
    logic [15:0] model_seg [4];

    always #2 clk = ~clk;

    seg_addr_gen u_dut (
        .clk(clk), .rst_n(rst_n),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .req_valid(req_valid), .req_role(req_role), .req_offset(req_offset),
        .ovr_valid(ovr_valid), .ovr_sel(ovr_sel), .hma_en(hma_en),
        .out_valid(out_valid), .phys_addr(phys_addr),
        .above_1m(above_1m), .seg_used(seg_used)
    );

    function automatic logic [1:0] exp_seg(input logic [2:0] role, input logic ov,
                                           input logic [1:0] os);
        if (ov) return os;
        case (role)
            3'd0:       return 2'd0;
            3'd1, 3'd2: return 2'd3;
            3'd5:       return 2'd2;
            default:    return 2'd1;
        endcase
    endfunction

    function automatic logic [20:0] raw_sum(input logic [15:0] s, input logic [15:0] o);
        return {1'b0, s, 4'b0} + {5'b0, o};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_seg(input logic [1:0] sel, input logic [15:0] val);
        @(negedge clk);
        seg_wr_en = 1'b1; seg_wr_sel = sel; seg_wr_data = val;
        @(negedge clk);
        seg_wr_en = 1'b0;
        model_seg[sel] = val;
    endtask

    // issue a request; optionally a write on the same edge; checks result
    task automatic do_req(input string req, input logic [2:0] role, input logic [15:0] off,
                          input logic ov, input logic [1:0] os, input logic hm,
                          input logic also_wr, input logic [1:0] wsel, input logic [15:0] wval);
        logic [1:0]  s;
        logic [20:0] r;
        logic [20:0] ea;
        @(negedge clk);
        req_valid = 1'b1; req_role = role; req_offset = off;
        ovr_valid = ov; ovr_sel = os; hma_en = hm;
        seg_wr_en = also_wr; seg_wr_sel = wsel; seg_wr_data = wval;
        s  = exp_seg(role, ov, os);
        r  = raw_sum(model_seg[s], off);
        ea = {r[20] & hm, r[19:0]};
        @(negedge clk);
        req_valid = 1'b0; seg_wr_en = 1'b0; ovr_valid = 1'b0;
        if (also_wr) model_seg[wsel] = wval;
        chk({req, " valid"}, 32'(out_valid), 32'd1);
        chk({req, " addr"},  32'(phys_addr), 32'(ea));
        chk({req, " above"}, 32'(above_1m), 32'(r[20]));
        chk({req, " seg"},   32'(seg_used), 32'(s));
        // R12: idle cycle holds result
        @(negedge clk);
        chk("R12 idle valid", 32'(out_valid), 32'd0);
        chk("R12 idle hold addr", 32'(phys_addr), 32'(ea));
        chk("R12 idle hold seg", 32'(seg_used), 32'(s));
    endtask

    initial begin
        #200000;
        bad++; total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 4; i++) model_seg[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1 valid", 32'(out_valid), 0);
        chk("R1 addr", 32'(phys_addr), 0);
        chk("R1 above", 32'(above_1m), 0);
        chk("R1 seg", 32'(seg_used), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 32'(out_valid), 0);
        for (int i = 0; i < 4; i++)
            do_req("R1 bank zero", 3'd0, 16'h0, 1'b1, 2'(i), 1'b0, 1'b0, 0, 0);

        // R2 directed example
        wr_seg(2'd1, 16'h1000);
        do_req("R2 1000:2000", 3'd3, 16'h2000, 1'b0, 0, 1'b0, 1'b0, 0, 0);
        chk("R2 example", 32'(phys_addr), 32'h12000);

        wr_seg(2'd0, 16'h2000);
        wr_seg(2'd2, 16'h4900);
        wr_seg(2'd3, 16'h3400);
        do_req("R3 ip->code", 3'd0, 16'h0010, 1'b0, 0, 1'b0, 1'b0, 0, 0);
        do_req("R4 sp->stack", 3'd1, 16'h0100, 1'b0, 0, 1'b0, 1'b0, 0, 0);
        do_req("R4 bp->stack", 3'd2, 16'hFFFF, 1'b0, 0, 1'b0, 1'b0, 0, 0);
        do_req("R5 base->data", 3'd3, 16'h0001, 1'b0, 0, 1'b0, 1'b0, 0, 0);
        do_req("R5 src->data", 3'd4, 16'h8000, 1'b0, 0, 1'b0, 1'b0, 0, 0);
        do_req("R5 direct->data", 3'd6, 16'h1234, 1'b0, 0, 1'b0, 1'b0, 0, 0);
        do_req("R5 spare->data", 3'd7, 16'h0042, 1'b0, 0, 1'b0, 1'b0, 0, 0);
        do_req("R6 dststr->extra", 3'd5, 16'h0F00, 1'b0, 0, 1'b0, 1'b0, 0, 0);
        do_req("R7 override", 3'd0, 16'h0004, 1'b1, 2'd3, 1'b0, 1'b0, 0, 0);
        do_req("R7 override es", 3'd1, 16'h0004, 1'b1, 2'd2, 1'b0, 1'b0, 0, 0);

        // R8/R9/R10 high memory corners
        wr_seg(2'd1, 16'hFFFF);
        do_req("R8 FFFF:FFFF", 3'd3, 16'hFFFF, 1'b0, 0, 1'b1, 1'b0, 0, 0);
        chk("R8 top", 32'(phys_addr), 32'h10FFEF);
        do_req("R8 FFFF:0000", 3'd3, 16'h0000, 1'b0, 0, 1'b1, 1'b0, 0, 0);
        chk("R8 bottom", 32'(phys_addr), 32'h0FFFF0);
        do_req("R9 wrap", 3'd3, 16'h0010, 1'b0, 0, 1'b0, 1'b0, 0, 0);
        chk("R9 wrap addr", 32'(phys_addr), 32'h0);
        chk("R10 flag masked", 32'(above_1m), 32'd1);
        do_req("R10 just below", 3'd3, 16'h000F, 1'b0, 0, 1'b0, 1'b0, 0, 0);
        chk("R10 below flag", 32'(above_1m), 32'd0);

        // R11 same-cycle write sees old value, next sees new
        do_req("R11 same cycle old", 3'd3, 16'h0020, 1'b0, 0, 1'b1, 1'b1, 2'd1, 16'h0ABC);
        do_req("R11 next new", 3'd3, 16'h0020, 1'b0, 0, 1'b1, 1'b0, 0, 0);
        chk("R11 new value", 32'(phys_addr), 32'h0ABE0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            if (($urandom % 4) == 0)
                wr_seg(2'($urandom), 16'($urandom));
            else
                do_req("R2 random", 3'($urandom), 16'($urandom), 1'($urandom % 4 == 0),
                       2'($urandom), 1'($urandom), 1'($urandom % 5 == 0),
                       2'($urandom), 16'($urandom));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule